// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block holds one pending flag for each of seven interrupt sources. When the core asks for a trap decision, it picks the single source that should trap next. A post strobe with a source index marks a source pending. A take strobe asks the block to evaluate its flags against the current control state: privilege mode, interrupt enable, trap level, the tick-pending bit, the software interrupt register and the processor interrupt level.

The decision is combinational in the cycle of the take strobe. The flags change on the next clock edge. A delivered source drops its flag. A pending hardware vector can also be consumed silently, with no trap. A blocked source stays pending. The software interrupt flag is kept after a delivery while other levels remain set in the software interrupt register.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset no source is pending and `any_pend` is low. From then on, `any_pend` is high exactly when at least one source flag is set.
- R2: A post with `post_idx` 0..6 sets that source's flag. The codes are 0 trap-level-zero, 1 tick match, 2 hardware vector, 3 CPU queue, 4 device queue, 5 resumable error, 6 software interrupt. Index 7 raises `post_err` in the same cycle and leaves every flag unchanged.
- R3: In privileged mode with interrupts enabled, a take delivers a pending tick match if `hintp0` is set. Otherwise a pending hardware vector is consumed with `take_vld` low.
- R4: In privileged mode with interrupts disabled, a take delivers nothing and clears no flag.
- R5: In non-privileged mode the priority is as follows. Trap-level-zero comes first, and only when `tlz_en` is set and `trap_lvl` is 0. Tick match comes next, and only when `hintp0` is set. Then, only when `ie` is set, the order is CPU queue, device queue, software interrupt, resumable error.
- R6: The software level is the index of the highest set bit among bits 15..1 of `softint`, or 0 if none is set. Suppose the software interrupt is reached with that level below 6 and a hardware vector pending. Then the vector is consumed instead, with no trap.
- R7: A software interrupt is delivered only when its level is strictly above `pil`. In that case `trap_id` is 6 and `soft_lvl` shows the level, and `soft_lvl` is 0 on every other cycle. A blocked software interrupt lets a resumable error be delivered.
- R8: After a software interrupt is delivered, its flag stays set if bits 15..1 of `softint` still hold another set bit once the serviced level is removed. Otherwise the flag clears.
- R9: A delivered or consumed source's flag is clear from the next edge on. Every other flag keeps its value.
- R10: If a post hits a source in the same cycle that it is cleared, the flag stays set. The internal count of pending sources always equals the number of set flags.
- R11: `take_vld` is high only in a cycle where `take` is high, and `trap_id` is meaningful only while `take_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_vld | input | 1 | Post strobe |
| post_idx | input | 3 | Source index for a post |
| take | input | 1 | Evaluate and take strobe |
| hpriv | input | 1 | Privileged (hypervisor) mode |
| ie | input | 1 | Interrupt enable |
| tlz_en | input | 1 | Trap-level-zero trap enable |
| trap_lvl | input | 3 | Current trap level |
| hintp0 | input | 1 | Tick-pending bit 0 |
| softint | input | 16 | Software interrupt register |
| pil | input | 4 | Processor interrupt level |
| any_pend | output | 1 | At least one source pending |
| post_err | output | 1 | Post with an invalid index |
| take_vld | output | 1 | Trap delivered this cycle |
| trap_id | output | 3 | Code of the delivered source |
| soft_lvl | output | 4 | Software level for a software trap, else 0 |

## Verification
The assertions assume that `post_vld`, `post_idx` and `take` hold steady between clock edges. They also assume that the control-state inputs are stable when `take` is sampled. The stimulus meets both conditions by changing every input only at the falling edge.

Random `softint` values are built by AND-ing several random words. This keeps the values sparse, so that remaining-level cases and levels on both sides of 6 and of `pil` all occur. Invalid index 7 is drawn as often as any valid code, so the no-change rule for a bad post is exercised on its own.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NSRC  = 7;
  localparam int IDX_W = 3;
  localparam int CNT_W = $clog2(NSRC + 1);

  typedef enum logic [IDX_W-1:0] {
    SRC_TLZ  = 3'd0,
    SRC_TICK = 3'd1,
    SRC_VEC  = 3'd2,
    SRC_CPUQ = 3'd3,
    SRC_DEVQ = 3'd4,
    SRC_RERR = 3'd5,
    SRC_SOFT = 3'd6
  } src_e;
endpackage

// File: rtl/irq_soft_lvl.sv
// Highest set level among bits SI_W-1..1 and whether another level remains.
module irq_soft_lvl #(
  parameter int SI_W  = 16,
  parameter int LVL_W = $clog2(SI_W)
) (
  input  logic [SI_W-1:0]  softint,
  output logic [LVL_W-1:0] lvl,
  output logic             rest_any
);
  logic [SI_W-1:0] masked;

  always_comb begin
    lvl = '0;
    for (int i = 1; i < SI_W; i++) begin
      if (softint[i]) lvl = LVL_W'(i);
    end
  end

  always_comb begin
    masked      = softint;
    masked[0]   = 1'b0;
    masked[lvl] = 1'b0;
    rest_any    = |masked;
  end
endmodule

// File: rtl/irq_pend_bank.sv
// Pending flags with post-wins merge and an incrementally kept count.
module irq_pend_bank
  import irq_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_vld,
  input  logic [IDX_W-1:0] post_idx,
  input  logic [NSRC-1:0]  clr,
  output logic [NSRC-1:0]  pend_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             post_err
);
  logic [NSRC-1:0]  post_hit;
  logic [NSRC-1:0]  pend_d;
  logic [NSRC-1:0]  rise;
  logic [NSRC-1:0]  fall;
  logic [CNT_W-1:0] cnt_d;
  logic             upd_en;

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign post_hit[g] = post_vld && (post_idx == IDX_W'(g));
  end

  assign post_err = post_vld && (int'(post_idx) >= NSRC);

  always_comb begin
    pend_d = post_hit | (pend_q & ~clr);
    rise   = pend_d & ~pend_q;
    fall   = pend_q & ~pend_d;
    cnt_d  = cnt_q + CNT_W'($countones(rise)) - CNT_W'($countones(fall));
    upd_en = (|post_hit) || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
// Mode-dependent priority decision; purely combinational.
module irq_arbiter
  import irq_sel_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int VEC_LIM = 6
) (
  input  logic [NSRC-1:0]  pend,
  input  logic             take,
  input  logic             hpriv,
  input  logic             ie,
  input  logic             tlz_en,
  input  logic             tl_zero,
  input  logic             hintp0,
  input  logic [LVL_W-1:0] lvl,
  input  logic             rest_any,
  input  logic [LVL_W-1:0] pil,
  output logic             take_vld,
  output logic [IDX_W-1:0] trap_id,
  output logic [NSRC-1:0]  clr
);
  logic deliver;
  logic eat_vec;
  logic keep_soft;
  src_e sel;

  always_comb begin
    deliver   = 1'b0;
    eat_vec   = 1'b0;
    keep_soft = 1'b0;
    sel       = SRC_TLZ;
    if (hpriv) begin
      if (ie) begin
        if (pend[SRC_TICK] && hintp0) begin
          deliver = 1'b1; sel = SRC_TICK;
        end else if (pend[SRC_VEC]) begin
          eat_vec = 1'b1;
        end
      end
    end else begin
      if (pend[SRC_TLZ] && tlz_en && tl_zero) begin
        deliver = 1'b1; sel = SRC_TLZ;
      end else if (pend[SRC_TICK] && hintp0) begin
        deliver = 1'b1; sel = SRC_TICK;
      end else if (ie) begin
        if (pend[SRC_CPUQ]) begin
          deliver = 1'b1; sel = SRC_CPUQ;
        end else if (pend[SRC_DEVQ]) begin
          deliver = 1'b1; sel = SRC_DEVQ;
        end else if (pend[SRC_SOFT] && (int'(lvl) < VEC_LIM) && pend[SRC_VEC]) begin
          eat_vec = 1'b1;
        end else if (pend[SRC_SOFT] && (lvl > pil)) begin
          deliver = 1'b1; sel = SRC_SOFT; keep_soft = rest_any;
        end else if (pend[SRC_RERR]) begin
          deliver = 1'b1; sel = SRC_RERR;
        end
      end
    end
  end

  always_comb begin
    clr = '0;
    if (take) begin
      if (deliver && !(sel == SRC_SOFT && keep_soft)) clr[sel] = 1'b1;
      if (eat_vec) clr[SRC_VEC] = 1'b1;
    end
  end

  assign take_vld = take && deliver;
  assign trap_id  = sel;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int SI_W    = 16,
  parameter int TL_W    = 3,
  parameter int VEC_LIM = 6,
  localparam int LVL_W  = $clog2(SI_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_vld,
  input  logic [2:0]       post_idx,
  input  logic             take,
  input  logic             hpriv,
  input  logic             ie,
  input  logic             tlz_en,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic             hintp0,
  input  logic [SI_W-1:0]  softint,
  input  logic [LVL_W-1:0] pil,
  output logic             any_pend,
  output logic             post_err,
  output logic             take_vld,
  output logic [2:0]       trap_id,
  output logic [LVL_W-1:0] soft_lvl
);
  logic [NSRC-1:0]  pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  clr;
  logic [LVL_W-1:0] lvl;
  logic             rest_any;

  irq_soft_lvl #(.SI_W(SI_W), .LVL_W(LVL_W)) u_lvl (
    .softint (softint),
    .lvl     (lvl),
    .rest_any(rest_any)
  );

  irq_pend_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .post_vld(post_vld),
    .post_idx(post_idx),
    .clr     (clr),
    .pend_q  (pend_q),
    .cnt_q   (cnt_q),
    .post_err(post_err)
  );

  irq_arbiter #(.LVL_W(LVL_W), .VEC_LIM(VEC_LIM)) u_arb (
    .pend    (pend_q),
    .take    (take),
    .hpriv   (hpriv),
    .ie      (ie),
    .tlz_en  (tlz_en),
    .tl_zero (trap_lvl == '0),
    .hintp0  (hintp0),
    .lvl     (lvl),
    .rest_any(rest_any),
    .pil     (pil),
    .take_vld(take_vld),
    .trap_id (trap_id),
    .clr     (clr)
  );

  assign any_pend = (cnt_q != '0);
  assign soft_lvl = (take_vld && trap_id == SRC_SOFT) ? lvl : '0;
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk
  import irq_sel_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             post_vld,
  input logic [2:0]       post_idx,
  input logic             take,
  input logic             hpriv,
  input logic             ie,
  input logic [3:0]       pil,
  input logic             any_pend,
  input logic             post_err,
  input logic             take_vld,
  input logic [2:0]       trap_id,
  input logic [3:0]       soft_lvl,
  input logic [NSRC-1:0]  pend,
  input logic [CNT_W-1:0] cnt
);
  p_anyp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend == (pend != '0));

  p_bad_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld && post_idx == 3'd7 && !take) |=> (pend == $past(pend)));

  p_err_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld && post_idx == 3'd7) |-> post_err);

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hpriv && !ie && !post_vld) |=> (pend == $past(pend)));

  p_soft_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vld && trap_id == SRC_SOFT) |-> (soft_lvl > pil));

  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vld && trap_id != SRC_SOFT && !(post_vld && post_idx == trap_id))
      |=> !pend[$past(trap_id)]);

  p_post_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld && post_idx != 3'd7) |=> pend[$past(post_idx)]);

  p_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == $countones(pend));

  p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_vld |-> take);
endmodule

bind irq_prio_sel irq_prio_sel_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .post_vld(post_vld),
  .post_idx(post_idx),
  .take    (take),
  .hpriv   (hpriv),
  .ie      (ie),
  .pil     (pil),
  .any_pend(any_pend),
  .post_err(post_err),
  .take_vld(take_vld),
  .trap_id (trap_id),
  .soft_lvl(soft_lvl),
  .pend    (pend_q),
  .cnt     (cnt_q)
);

// File: tb/irq_prio_sel_tb.sv
`timescale 1ns/1ps
module irq_prio_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_vld, take, hpriv, ie, tlz_en, hintp0;
  logic [2:0]  post_idx, trap_lvl;
  logic [15:0] softint;
  logic [3:0]  pil;
  logic        any_pend, post_err, take_vld;
  logic [2:0]  trap_id;
  logic [3:0]  soft_lvl;

  int n_chk = 0;
  int n_fail = 0;

  logic [6:0]  m_pend;
  logic        e_vld;
  logic [2:0]  e_id;
  logic [3:0]  e_lvl;
  logic [6:0]  e_clr;
  string       e_tag;
  string       p_tag = "R1";

  always #2 clk = ~clk;

  irq_prio_sel u_dut (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_idx(post_idx),
    .take(take), .hpriv(hpriv), .ie(ie), .tlz_en(tlz_en),
    .trap_lvl(trap_lvl), .hintp0(hintp0), .softint(softint), .pil(pil),
    .any_pend(any_pend), .post_err(post_err), .take_vld(take_vld),
    .trap_id(trap_id), .soft_lvl(soft_lvl)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference decision written from the requirement list.
  task automatic model();
    int lv;
    bit rest;
    bit hit;
    lv = 0;
    for (int i = 1; i < 16; i++) if (softint[i]) lv = i;
    rest = 1'b0;
    for (int i = 1; i < 16; i++) if (softint[i] && i != lv) rest = 1'b1;
    e_vld = 0; e_id = 0; e_lvl = 0; e_clr = 0; hit = 0;
    if (hpriv) begin
      e_tag = ie ? "R3" : "R4";
      if (ie) begin
        if (m_pend[1] && hintp0) begin hit = 1; e_id = 1; e_clr = 7'b0000010; end
        else if (m_pend[2]) e_clr = 7'b0000100;
      end
    end else begin
      e_tag = "R5";
      if (m_pend[0] && tlz_en && trap_lvl == 0) begin hit = 1; e_id = 0; e_clr = 7'b0000001; end
      else if (m_pend[1] && hintp0) begin hit = 1; e_id = 1; e_clr = 7'b0000010; end
      else if (ie) begin
        if (m_pend[3]) begin hit = 1; e_id = 3; e_clr = 7'b0001000; end
        else if (m_pend[4]) begin hit = 1; e_id = 4; e_clr = 7'b0010000; end
        else if (m_pend[6] && lv < 6 && m_pend[2]) begin e_tag = "R6"; e_clr = 7'b0000100; end
        else if (m_pend[6] && lv > int'(pil)) begin
          hit = 1; e_id = 6; e_lvl = 4'(lv);
          e_tag = rest ? "R8" : "R7";
          e_clr = rest ? 7'b0 : 7'b1000000;
        end else if (m_pend[5]) begin
          hit = 1; e_id = 5; e_clr = 7'b0100000;
          if (m_pend[6]) e_tag = "R7";
        end
      end
    end
    if (!take) begin e_clr = 0; e_tag = "R11"; end
    e_vld = take && hit;
    if (!e_vld) begin e_lvl = 0; end
  endtask

  // Inputs are set at a falling edge; this checks and then advances one cycle.
  task automatic step();
    logic [6:0] hitm, nxt;
    #1;
    model();
    chk(p_tag, "any_pend", any_pend, |m_pend);
    chk("R2", "post_err", post_err, post_vld && post_idx == 3'd7);
    chk(e_tag, "take_vld", take_vld, e_vld);
    if (e_vld) chk(e_tag, "trap_id", trap_id, e_id);
    chk(e_vld && e_id == 6 ? e_tag : "R7", "soft_lvl", soft_lvl, e_lvl);
    hitm = (post_vld && post_idx != 3'd7) ? 7'(1 << post_idx) : 7'b0;
    nxt  = hitm | (m_pend & ~e_clr);
    if (|(hitm & e_clr)) p_tag = "R10";
    else if (post_vld && post_idx == 3'd7) p_tag = "R2";
    else if (take) p_tag = "R9";
    else p_tag = "R1";
    @(posedge clk);
    m_pend = nxt;
    @(negedge clk);
  endtask

  task automatic idle();
    post_vld = 0; post_idx = 0; take = 0; hpriv = 0; ie = 1; tlz_en = 0;
    trap_lvl = 1; hintp0 = 0; softint = 0; pil = 0;
  endtask

  task automatic post(input int idx);
    idle(); post_vld = 1; post_idx = 3'(idx); step();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    m_pend = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset any_pend", any_pend, 0);
    rst_n = 1;
    @(negedge clk);
    idle(); take = 1; step();                       // nothing pending
    post(7);                                        // bad index
    idle(); step();
    // vector under a low software level is eaten first
    post(2); post(6);
    idle(); take = 1; softint = 16'h0008; step();
    idle(); take = 1; softint = 16'h0008; pil = 2; step();
    // two levels set: flag survives first delivery
    post(6);
    idle(); take = 1; softint = 16'h0900; pil = 1; step();
    idle(); take = 1; softint = 16'h0100; pil = 1; step();
    // privileged with interrupts off holds everything
    post(1); post(2);
    idle(); take = 1; hpriv = 1; ie = 0; hintp0 = 1; step();
    idle(); take = 1; hpriv = 1; ie = 1; hintp0 = 0; step();
    idle(); take = 1; hpriv = 1; ie = 1; hintp0 = 1; step();
    // post and delivery of the same source in one cycle
    post(3);
    idle(); take = 1; post_vld = 1; post_idx = 3; step();
    idle(); step();
    // trap-level-zero gating
    post(0);
    idle(); take = 1; tlz_en = 1; trap_lvl = 2; ie = 0; step();
    idle(); take = 1; tlz_en = 1; trap_lvl = 0; ie = 0; step();
    // blocked software interrupt lets resumable error through
    post(6); post(5);
    idle(); take = 1; softint = 16'h0080; pil = 9; step();
    for (int n = 0; n < 4000; n++) begin
      post_vld = ($urandom % 10) < 4;
      post_idx = 3'($urandom % 8);
      take     = ($urandom % 2) == 0;
      hpriv    = ($urandom % 10) < 3;
      ie       = ($urandom % 10) < 7;
      tlz_en   = $urandom % 2;
      trap_lvl = ($urandom % 2) ? 3'd0 : 3'($urandom);
      hintp0   = $urandom % 2;
      softint  = 16'($urandom & $urandom & $urandom);
      pil      = 4'($urandom % 16);
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule